// File: doc/BRIEF.md
# Frame-Aware Interface Enable Controller

This block is the enable and disable sequencer for a serial camera receiver. It watches the software interface-enable level, a frame-mode setting and a checksum-trailer setting. It also takes event strobes from the line decoder: start-of-frame with a channel number, end-of-frame with a channel number, and one strobe for each received data beat. From these it drives a data-acquisition enable for the datapath, a one-cycle reset pulse for the output FIFO, a busy flag, and a one-cycle reception-ended pulse.

Acquisition never starts in the middle of a frame. After the enable is raised, the block waits for a start-of-frame on an enabled channel. A disable request is honoured at a point that depends on the settings:
- With frame mode off, it takes effect at once.
- With frame mode on, it waits until every channel that was enabled at the moment of the request has delivered its end-of-frame.
- With the trailer setting on, it also waits for the 16-bit checksum word and then the 16-bit pad word.

Raising the enable again while a drain is under way resumes acquisition, and the FIFO is not reset.

All pins are plain control and status levels or single-cycle event strobes. The decoder events carry no payload, so there is no valid/ready handshake and no back-pressure. A strobe counts in the cycle it is high and is never stalled.

Top module: `frame_enable_ctrl`

## Requirements
- R1: After reset, busy, acq_en, fifo_rst and rx_done are all 0.
- R2: A 0-to-1 change of if_en while the block is idle produces exactly one fifo_rst pulse, in the cycle after the change. Keeping if_en high produces no further pulse.
- R3: After enabling, acq_en stays 0 until sof_vld arrives with a sof_ch whose chan_en bit is 1. acq_en then rises in the next cycle. A start-of-frame on a disabled channel is ignored.
- R4: With frame_mode = 0, clearing if_en during acquisition drops acq_en and busy in the next cycle.
- R5: With frame_mode = 1 and crc_mode = 0, acq_en stays 1 after if_en is cleared. It falls in the cycle after the last outstanding end-of-frame.
- R6: The set of outstanding channels is the chan_en bits at the moment if_en is cleared. Each of these channels needs its own eof_vld/eof_ch. An end-of-frame on a channel outside the set does not end the drain.
- R7: With frame_mode = 1 and crc_mode = 1, acquisition continues after the last end-of-frame for 2 × (16 / BEAT_BITS) further beat_vld strobes: the checksum word, then the pad word. It falls in the cycle after the last of these beats.
- R8: Raising if_en during any drain phase keeps acq_en at 1 and produces no fifo_rst.
- R9: busy is 1 in every state except idle. rx_done is a one-cycle pulse in the first idle cycle after any non-idle state.
- R10: Clearing if_en while waiting for a start-of-frame returns the block to idle in the next cycle.
- R11: With frame_mode = 1, clearing if_en while no chan_en bit is set stops acquisition in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| if_en | input | 1 | Interface enable level from software |
| frame_mode | input | 1 | 1 = a disable waits for frame ends |
| crc_mode | input | 1 | 1 = a disable also waits for the checksum and pad words |
| chan_en | input | NUM_CH | Per-channel enables |
| sof_vld | input | 1 | Start-of-frame strobe from the decoder |
| sof_ch | input | CH_W | Channel of the start-of-frame |
| eof_vld | input | 1 | End-of-frame strobe from the decoder |
| eof_ch | input | CH_W | Channel of the end-of-frame |
| beat_vld | input | 1 | One strobe for each BEAT_BITS-wide received unit |
| acq_en | output | 1 | Data-acquisition enable |
| fifo_rst | output | 1 | One-cycle output-FIFO reset |
| busy | output | 1 | High whenever the block is not idle |
| rx_done | output | 1 | One-cycle pulse when reception has ended |

## Verification
The assertions take for granted that frame_mode, crc_mode and chan_en hold steady while acquisition is running. The one exception is the dedicated case where chan_en is cleared just before the disable. They also assume that event strobes last one cycle and that the channel fields carry an index below NUM_CH. The stimulus changes settings only while the block is idle and pulses every strobe for exactly one cycle. It sweeps all fifteen non-empty channel masks under each of the three disable modes. It sends decoy start- and end-of-frame events only on channels that are disabled or outside the outstanding set.

// File: rtl/fen_pkg.sv
package fen_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_WAIT_SOF  = 3'd1,
    ST_ACTIVE    = 3'd2,
    ST_DRAIN_EOF = 3'd3,
    ST_DRAIN_CRC = 3'd4,
    ST_DRAIN_PAD = 3'd5
  } fen_state_e;
endpackage

// File: rtl/fen_edge_det.sv
module fen_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/fen_chan_track.sv
module fen_chan_track #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] chan_en,
  input  logic              eof_vld,
  input  logic [CH_W-1:0]   eof_ch,
  input  logic              load,
  input  logic              hold,
  output logic              any_en,
  output logic              load_empty,
  output logic              drain_done
);
  logic [NUM_CH-1:0] hit;
  logic [NUM_CH-1:0] pend_q;
  logic [NUM_CH-1:0] pend_d;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign hit[i] = eof_vld && (eof_ch == CH_W'(i));

    always_comb begin
      if (load)      pend_d[i] = chan_en[i] & ~hit[i];
      else if (hold) pend_d[i] = pend_q[i] & ~hit[i];
      else           pend_d[i] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[i] <= 1'b0;
      else        pend_q[i] <= pend_d[i];
    end

    // R6: an outstanding channel stays outstanding until its own end-of-frame
    assert_pend_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !load && pend_q[i] && !hit[i]) |=> pend_q[i]);
  end

  assign any_en     = |chan_en;
  assign load_empty = ~|(chan_en & ~hit);
  assign drain_done = ~|(pend_q & ~hit);
endmodule

// File: rtl/fen_trail_cnt.sv
module fen_trail_cnt #(
  parameter int BEATS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic beat_vld,
  output logic word_done
);
  localparam int CW = $clog2(BEATS) + 1;
  logic [CW-1:0] cnt_q;

  assign word_done = active && beat_vld && (cnt_q == CW'(BEATS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (!active || word_done) cnt_q <= '0;
    else if (beat_vld)            cnt_q <= cnt_q + CW'(1);
  end

  // R7: the count never runs past one trailer word
  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(BEATS));
endmodule

// File: rtl/fen_fsm.sv
module fen_fsm
  import fen_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic if_en,
  input  logic if_rise,
  input  logic frame_mode,
  input  logic crc_mode,
  input  logic sof_hit,
  input  logic any_en,
  input  logic load_empty,
  input  logic drain_done,
  input  logic word_done,
  output logic load,
  output logic hold,
  output logic trail_active,
  output logic acq_en,
  output logic busy,
  output logic fifo_rst,
  output logic rx_done
);
  fen_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    load = 1'b0;
    unique case (st_q)
      ST_IDLE:     if (if_rise) st_d = ST_WAIT_SOF;
      ST_WAIT_SOF: begin
        if (!if_en)       st_d = ST_IDLE;
        else if (sof_hit) st_d = ST_ACTIVE;
      end
      ST_ACTIVE: begin
        if (!if_en) begin
          if (!frame_mode || !any_en) st_d = ST_IDLE;
          else begin
            load = 1'b1;
            if (load_empty) st_d = crc_mode ? ST_DRAIN_CRC : ST_IDLE;
            else            st_d = ST_DRAIN_EOF;
          end
        end
      end
      ST_DRAIN_EOF: begin
        if (if_en)           st_d = ST_ACTIVE;
        else if (drain_done) st_d = crc_mode ? ST_DRAIN_CRC : ST_IDLE;
      end
      ST_DRAIN_CRC: begin
        if (if_en)          st_d = ST_ACTIVE;
        else if (word_done) st_d = ST_DRAIN_PAD;
      end
      ST_DRAIN_PAD: begin
        if (if_en)          st_d = ST_ACTIVE;
        else if (word_done) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      fifo_rst <= 1'b0;
      rx_done  <= 1'b0;
    end else begin
      st_q     <= st_d;
      fifo_rst <= (st_q == ST_IDLE) && if_rise;
      rx_done  <= (st_q != ST_IDLE) && (st_d == ST_IDLE);
    end
  end

  assign hold         = (st_q == ST_DRAIN_EOF);
  assign trail_active = (st_q == ST_DRAIN_CRC) || (st_q == ST_DRAIN_PAD);
  assign busy         = (st_q != ST_IDLE);
  assign acq_en       = (st_q == ST_ACTIVE) || (st_q == ST_DRAIN_EOF) || trail_active;

  assert_rst_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rst |=> !fifo_rst);
  assert_rst_waiting_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rst |-> (busy && !acq_en));
  assert_no_early_acq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT_SOF && !sof_hit) |=> !acq_en);
  assert_immediate_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ACTIVE && !if_en && !frame_mode) |=> !busy);
  assert_keep_running_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_en && if_en) |=> (acq_en && !fifo_rst));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> (!busy && $past(busy)));
  assert_acq_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acq_en |-> busy);
  assert_wait_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT_SOF && !if_en) |=> (!busy && rx_done));
  assert_no_chan_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ACTIVE && !if_en && !any_en) |=> !acq_en);
endmodule

// File: rtl/frame_enable_ctrl.sv
module frame_enable_ctrl #(
  parameter int NUM_CH     = 4,
  parameter int BEAT_BITS  = 8,
  parameter int TRAIL_BITS = 16,
  localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              if_en,
  input  logic              frame_mode,
  input  logic              crc_mode,
  input  logic [NUM_CH-1:0] chan_en,
  input  logic              sof_vld,
  input  logic [CH_W-1:0]   sof_ch,
  input  logic              eof_vld,
  input  logic [CH_W-1:0]   eof_ch,
  input  logic              beat_vld,
  output logic              acq_en,
  output logic              fifo_rst,
  output logic              busy,
  output logic              rx_done
);
  localparam int BEATS = (TRAIL_BITS / BEAT_BITS > 0) ? TRAIL_BITS / BEAT_BITS : 1;

  logic if_rise, sof_hit, any_en, load_empty, drain_done;
  logic word_done, load, hold, trail_active;
  logic [NUM_CH-1:0] sof_dec;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_sof
    assign sof_dec[i] = sof_vld && (sof_ch == CH_W'(i)) && chan_en[i];
  end
  assign sof_hit = |sof_dec;

  fen_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(if_en), .rise(if_rise)
  );

  fen_chan_track #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_track (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en),
    .eof_vld(eof_vld), .eof_ch(eof_ch), .load(load), .hold(hold),
    .any_en(any_en), .load_empty(load_empty), .drain_done(drain_done)
  );

  fen_trail_cnt #(.BEATS(BEATS)) u_trail (
    .clk(clk), .rst_n(rst_n), .active(trail_active),
    .beat_vld(beat_vld), .word_done(word_done)
  );

  fen_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .if_en(if_en), .if_rise(if_rise),
    .frame_mode(frame_mode), .crc_mode(crc_mode), .sof_hit(sof_hit),
    .any_en(any_en), .load_empty(load_empty), .drain_done(drain_done),
    .word_done(word_done), .load(load), .hold(hold),
    .trail_active(trail_active), .acq_en(acq_en), .busy(busy),
    .fifo_rst(fifo_rst), .rx_done(rx_done)
  );

  // R5: with frame mode on, the disable request alone never ends acquisition while channels are outstanding
  assert_defer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_en && !hold && !trail_active && !if_en && frame_mode && !load_empty) |=> acq_en);
endmodule

// File: tb/frame_enable_ctrl_tb_top.sv
module frame_enable_ctrl_tb_top;
  localparam int NCH   = 4;
  localparam int CHW   = 2;
  localparam int BEATS = 16 / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic if_en = 0, frame_mode = 0, crc_mode = 0;
  logic [NCH-1:0] chan_en = '0;
  logic sof_vld = 0, eof_vld = 0, beat_vld = 0;
  logic [CHW-1:0] sof_ch = '0, eof_ch = '0;
  logic acq_en, fifo_rst, busy, rx_done;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  frame_enable_ctrl #(.NUM_CH(NCH), .BEAT_BITS(8), .TRAIL_BITS(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .if_en(if_en), .frame_mode(frame_mode),
    .crc_mode(crc_mode), .chan_en(chan_en), .sof_vld(sof_vld), .sof_ch(sof_ch),
    .eof_vld(eof_vld), .eof_ch(eof_ch), .beat_vld(beat_vld),
    .acq_en(acq_en), .fifo_rst(fifo_rst), .busy(busy), .rx_done(rx_done)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    sof_vld = 0; eof_vld = 0; beat_vld = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=<100000", cycles);
      finish_run();
    end
  end

  task automatic start(logic [NCH-1:0] m, logic fm, logic cm);
    chan_en = m; frame_mode = fm; crc_mode = cm;
    if_en = 1; tick();
    chk("R2 pulse", {29'd0, fifo_rst, busy, acq_en}, 32'b110);
    tick();
    chk("R2 single", fifo_rst, 0);
    for (int c = 0; c < NCH; c++) if (!m[c]) begin
      sof_vld = 1; sof_ch = CHW'(c); tick();
      chk("R3 ignored sof", acq_en, 0);
      break;
    end
    for (int c = 0; c < NCH; c++) if (m[c]) begin
      sof_vld = 1; sof_ch = CHW'(c); tick();
      chk("R3 start", acq_en, 1);
      break;
    end
    tick(); tick();
    chk("R2 steady", fifo_rst, 0);
  endtask

  task automatic trailer();
    for (int b = 0; b < 2 * BEATS; b++) begin
      tick();
      chk("R7 idle gap", acq_en, 1);
      beat_vld = 1; tick();
      if (b < 2 * BEATS - 1) chk("R7 trailer", acq_en, 1);
      else chk("R7 end", {30'd0, busy, rx_done}, 32'b01);
    end
  endtask

  task automatic run_case(int mode, logic [NCH-1:0] m);
    int last;
    start(m, mode != 0, mode == 2);
    if_en = 0; tick();
    if (mode == 0) begin
      chk("R4 off", {30'd0, busy, acq_en}, 0);
      chk("R9 done", rx_done, 1);
      tick();
      chk("R9 one cycle", rx_done, 0);
      return;
    end
    chk("R5 deferred", acq_en, 1);
    last = 0;
    for (int c = 0; c < NCH; c++) if (m[c]) last = c;
    for (int c = 0; c < NCH; c++) if (!m[c]) begin
      eof_vld = 1; eof_ch = CHW'(c); tick();
      chk("R6 foreign eof", acq_en, 1);
      break;
    end
    for (int c = 0; c < NCH; c++) if (m[c]) begin
      eof_vld = 1; eof_ch = CHW'(c); tick();
      if (c != last) chk("R6 outstanding", acq_en, 1);
      else if (mode == 1) chk("R5 end", {30'd0, busy, rx_done}, 32'b01);
      else chk("R7 crc wait", acq_en, 1);
    end
    if (mode == 2) trailer();
    tick();
    chk("R9 idle", {30'd0, busy, rx_done}, 0);
  endtask

  initial begin
    #1;
    chk("R1 reset", {28'd0, busy, acq_en, fifo_rst, rx_done}, 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    chk("R1 after release", {28'd0, busy, acq_en, fifo_rst, rx_done}, 0);

    for (int mode = 0; mode < 3; mode++)
      for (int m = 1; m < 16; m++) run_case(mode, NCH'(m));

    // R10: disable while waiting for start-of-frame
    chan_en = 4'b0011; frame_mode = 1; crc_mode = 1;
    if_en = 1; tick(); tick();
    if_en = 0; tick();
    chk("R10 wait off", {30'd0, busy, rx_done}, 32'b01);
    tick();

    // R11: frame mode, channels cleared before disable
    start(4'b0001, 1, 0);
    chan_en = 4'b0000; tick();
    if_en = 0; tick();
    chk("R11 no channel", {30'd0, busy, acq_en}, 0);
    tick();

    // R8: re-enable during each drain phase
    start(4'b0011, 1, 1);
    if_en = 0; tick();
    if_en = 1; tick();
    chk("R8 eof drain", {30'd0, acq_en, fifo_rst}, 32'b10);
    tick();
    chk("R8 no reset", {30'd0, acq_en, fifo_rst}, 32'b10);
    if_en = 0; tick();
    eof_vld = 1; eof_ch = 0; tick();
    eof_vld = 1; eof_ch = 1; tick();
    beat_vld = 1; tick();
    if_en = 1; tick();
    chk("R8 crc drain", {30'd0, acq_en, fifo_rst}, 32'b10);
    tick();
    chk("R8 crc no reset", fifo_rst, 0);
    if_en = 0; tick();
    eof_vld = 1; eof_ch = 0; tick();
    eof_vld = 1; eof_ch = 1; tick();
    for (int b = 0; b < BEATS; b++) begin beat_vld = 1; tick(); end
    beat_vld = 1; tick();
    if_en = 1; tick();
    chk("R8 pad drain", {30'd0, acq_en, fifo_rst}, 32'b10);
    if_en = 0; tick();
    eof_vld = 1; eof_ch = 0; tick();
    eof_vld = 1; eof_ch = 1; tick();
    trailer();
    tick();
    finish_run();
  end
endmodule